// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs one register access on the two-wire Ethernet PHY management channel. The host fills in a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value, and then pulses `start`. The master derives the management clock `mdc` from the system clock and drives the data line through separate value and enable outputs. An external pad buffer does the tri-stating. On reads, the master samples the returned line through a two-flop synchroniser. Every frame is a sequence of bit slots. In each slot `mdc` is low for `HALF_DIV` system clocks and then high for `HALF_DIV` system clocks. The master changes its drive only at the start of a slot.

A read whose turnaround bit comes back high is abandoned. The master then sends a run of recovery clocks with the line released and finishes with the error flag set. Every transaction ends with released-line clock slots, and then `done` pulses. The result and the error flag stay unchanged until the next request is accepted.

Top module: `mdio_master`

## Requirements
- R1: In reset and whenever `busy` is low, `mdc` is 0, `mdio_oe` is 0 and `mdio_o` is 0. After reset, `done`, `err` and `rd_data` are 0.
- R2: `start` is accepted only in a cycle where `busy` is low, and the request fields are captured in that cycle. A `start` pulse or field change while `busy` is high has no effect on the frame or on its result.
- R3: After acceptance, slot k has `mdc` low for `HALF_DIV` clocks and then high for `HALF_DIV` clocks. Slot k begins 2·`HALF_DIV`·k clocks after the accepting edge.
- R4: Slots 0–31 drive 1. Slots 32–33 drive 0 then 1. Slots 34–35 carry the operation: 1,0 for a read (`rd_wr`=1) and 0,1 for a write. Slots 36–40 carry `phy_addr` MSB first. Slots 41–45 carry `reg_addr` MSB first.
- R5: `mdio_o` and `mdio_oe` never change while `mdc` is high.
- R6: A write drives 1,0 in slots 46–47 and `wr_data` MSB first in slots 48–63. Slot 64 is released, and the frame is 65 slots long.
- R7: A read releases the line from slot 46 on. The line level at the end of the high half of slot 47 is the turnaround check. The bits at the end of the high halves of slots 48–63 form `rd_data`, MSB first. Slots 64–65 are released, and the frame is 66 slots long.
- R8: If the turnaround level on a read is 1, no data is collected. Slots 48–79 are released clock slots (80 slots in total). The frame then completes with `err`=1 and `rd_data`=0.
- R9: `busy` falls and `done` is 1 for exactly one clock at 2·`HALF_DIV`·(frame slots) clocks after the accepting edge. `rd_data` and `err` become 0 when a request is accepted, take their result together with `done`, and then hold until the next acceptance.
- R10: `mdio_i` passes through two register stages before it is sampled. A level that changes within the last two system clocks before a sampling edge is not seen by that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Value read (0 after a write or a failed read) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Turnaround check failed on the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value to drive |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line level from the pad |

## Verification
The hardest situations to reach from the ports are a failed turnaround and a line change that lands inside the synchroniser window. A plain read never produces either. The bench therefore contains a PHY model that drives the line only during the slots where a PHY would answer. That model can be told to return a high turnaround, which forces the abort and the 32-slot recovery. It can also be told to invert every returned bit two clocks before each sampling edge, which exposes any missing synchroniser stage. A stray `start` with changed fields is also injected mid-frame. The per-clock reference comparison then shows that the frame is unaffected.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_N      = 32;
    localparam int RECOV_N    = 32;

    localparam int ST_POS     = PRE_N;
    localparam int OP_POS     = ST_POS + 2;
    localparam int PHY_POS    = OP_POS + 2;
    localparam int REG_POS    = PHY_POS + ADDR_W;
    localparam int TA_POS     = REG_POS + ADDR_W;
    localparam int TA_CHK_POS = TA_POS + 1;
    localparam int DAT_POS    = TA_POS + 2;
    localparam int DAT_END    = DAT_POS + DATA_W - 1;
    localparam int WR_LAST    = DAT_END + 1;
    localparam int RD_LAST    = DAT_END + 2;
    localparam int AB_LAST    = TA_CHK_POS + RECOV_N;
    localparam int POS_W      = $clog2(AB_LAST + 1);

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic oe;
        logic val;
    } drv_t;

    // Line drive for a given slot of the frame.
    function automatic drv_t slot_drive(input logic [POS_W-1:0] pos, input req_t r);
        drv_t              d;
        int                p;
        logic [ADDR_W-1:0] ash;
        logic [DATA_W-1:0] dsh;
        p     = int'(pos);
        d.oe  = 1'b1;
        d.val = 1'b1;
        ash   = '0;
        dsh   = '0;
        if (p < ST_POS) begin
            d.val = 1'b1;
        end else if (p == ST_POS) begin
            d.val = 1'b0;
        end else if (p == ST_POS + 1) begin
            d.val = 1'b1;
        end else if (p == OP_POS) begin
            d.val = (r.op == OP_READ);
        end else if (p == OP_POS + 1) begin
            d.val = (r.op == OP_WRITE);
        end else if (p < REG_POS) begin
            ash   = r.phy << (p - PHY_POS);
            d.val = ash[ADDR_W-1];
        end else if (p < TA_POS) begin
            ash   = r.regad << (p - REG_POS);
            d.val = ash[ADDR_W-1];
        end else if (r.op == OP_READ) begin
            d.oe  = 1'b0;
            d.val = 1'b0;
        end else if (p == TA_POS) begin
            d.val = 1'b1;
        end else if (p == TA_POS + 1) begin
            d.val = 1'b0;
        end else if (p <= DAT_END) begin
            dsh   = r.wdata << (p - DAT_POS);
            d.val = dsh[DATA_W-1];
        end else begin
            d.oe  = 1'b0;
            d.val = 1'b0;
        end
        return d;
    endfunction

    function automatic logic [POS_W-1:0] last_pos(input req_t r, input logic abort);
        if (r.op == OP_WRITE) return POS_W'(WR_LAST);
        if (abort)            return POS_W'(AB_LAST);
        return POS_W'(RD_LAST);
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: a half period never runs past HALF_DIV clocks
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < HALF_DIV);

    // R3: each frame starts its first half period from zero
    a_r3_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= {STAGES{RST_VAL}};
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];

    // R10: the output is the input delayed by exactly STAGES clocks (checked for two)
    a_r10_two_stage: assert property (@(posedge clk) disable iff (rst)
        (STAGES == 2 && !$past(rst) && !$past(rst, 2)) |-> q == $past(d, 2));

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  req_t              req_in,
    input  logic              tick,
    input  logic              mdio_s,
    output logic              busy,
    output logic              done,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);
    req_t              req_q;
    drv_t              drv;
    logic [POS_W-1:0]  pos;
    logic              abort;
    logic [DATA_W-1:0] shreg;
    logic              is_rd;
    logic              in_data;
    logic              at_last;

    assign is_rd   = (req_q.op == OP_READ);
    assign in_data = (pos >= POS_W'(DAT_POS)) && (pos <= POS_W'(DAT_END));
    assign at_last = (pos == last_pos(req_q, abort));
    assign mdio_oe = drv.oe;
    assign mdio_o  = drv.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            mdc     <= 1'b0;
            pos     <= '0;
            abort   <= 1'b0;
            req_q   <= '0;
            drv     <= '0;
            shreg   <= '0;
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    req_q   <= req_in;
                    pos     <= '0;
                    mdc     <= 1'b0;
                    abort   <= 1'b0;
                    rd_data <= '0;
                    err     <= 1'b0;
                    drv     <= slot_drive('0, req_in);
                end
            end else if (tick) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                end else begin
                    mdc <= 1'b0;
                    if (is_rd && !abort && pos == POS_W'(TA_CHK_POS)) begin
                        abort <= mdio_s;
                    end
                    if (is_rd && !abort && in_data) begin
                        shreg <= {shreg[DATA_W-2:0], mdio_s};
                    end
                    if (at_last) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        drv     <= '0;
                        rd_data <= (is_rd && !abort) ? shreg : '0;
                        err     <= abort;
                    end else begin
                        pos <= pos + 1'b1;
                        drv <= slot_drive(pos + 1'b1, req_q);
                    end
                end
            end
        end
    end

    // R9: completion strobe lasts a single clock
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: line released and clock low whenever no frame runs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe && !mdio_o));

    // R2: a strobe during a frame leaves the captured request alone
    a_r2_hold_req: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));

    // R5: drive is frozen across the high half of the clock
    a_r5_stable_high: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7: reads never drive the line after the address field
    a_r7_released: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && pos >= POS_W'(TA_POS)) |-> !mdio_oe);

    // R8: a failed turnaround reports no data
    a_r8_err_no_data: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> rd_data == '0);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd_wr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    req_t req_in;
    logic tick;
    logic mdio_s;

    assign req_in.op    = rd_wr ? OP_READ : OP_WRITE;
    assign req_in.phy   = phy_addr;
    assign req_in.regad = reg_addr;
    assign req_in.wdata = wr_data;

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mdio_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mdio_i),
        .q   (mdio_s)
    );

    mdio_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req_in  (req_in),
        .tick    (tick),
        .mdio_s  (mdio_s),
        .busy    (busy),
        .done    (done),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (rd_data),
        .err     (err)
    );

endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_wr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic        mdio_i;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_master #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst(rst), .start(start), .rd_wr(rd_wr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .err(err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // PHY behaviour for the current transaction
    bit          ph_ta = 0;
    logic [15:0] ph_data = '0;
    bit          ph_late = 0;

    // reference model
    int          m_n = 0;
    int          m_nslots = 0;
    bit          m_busy = 0, m_done = 0, m_rd = 0, m_ta = 0, m_err_out = 0;
    logic [15:0] m_data = '0, m_rd_out = '0;
    logic [1:0]  m_q[$];

    task automatic build(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit ta);
        m_q.delete();
        for (int i = 0; i < 32; i++) m_q.push_back(2'b11);
        m_q.push_back(2'b10);
        m_q.push_back(2'b11);
        m_q.push_back(rd ? 2'b11 : 2'b10);
        m_q.push_back(rd ? 2'b10 : 2'b11);
        for (int i = 4; i >= 0; i--) m_q.push_back({1'b1, pa[i]});
        for (int i = 4; i >= 0; i--) m_q.push_back({1'b1, ra[i]});
        if (!rd) begin
            m_q.push_back(2'b11);
            m_q.push_back(2'b10);
            for (int i = 15; i >= 0; i--) m_q.push_back({1'b1, wd[i]});
            m_q.push_back(2'b00);
        end else if (ta) begin
            for (int i = 0; i < 34; i++) m_q.push_back(2'b00);
        end else begin
            for (int i = 0; i < 20; i++) m_q.push_back(2'b00);
        end
        m_nslots = m_q.size();
    endtask

    always @(posedge clk) begin
        m_done = 0;
        if (rst) begin
            m_busy = 0; m_n = 0; m_rd_out = '0; m_err_out = 0;
        end else if (m_busy) begin
            m_n++;
            if (m_n == 2 * H * m_nslots) begin
                m_busy = 0;
                m_done = 1;
                m_rd_out = (m_rd && !m_ta) ? m_data : 16'h0;
                m_err_out = m_rd && m_ta;
            end
        end else if (start) begin
            m_rd = rd_wr;
            m_ta = rd_wr ? ph_ta : 1'b0;
            m_data = ph_data;
            build(rd_wr, phy_addr, reg_addr, wr_data, m_ta);
            m_busy = 1; m_n = 0; m_rd_out = '0; m_err_out = 0;
        end
    end

    always @(negedge clk) begin
        int slot;
        bit exp_mdc;
        logic [1:0] exp_drv;
        string tg;
        slot = m_n / (2 * H);
        if (!rst && !finished) begin
            exp_mdc = m_busy && (((m_n / H) % 2) == 1);
            exp_drv = m_busy ? m_q[slot] : 2'b00;
            if (!m_busy) tg = "R1";
            else if (exp_mdc) tg = "R5";
            else if (slot < 46) tg = "R4";
            else if (!m_rd) tg = "R6";
            else if (m_ta && slot >= 48) tg = "R8";
            else tg = "R7";
            chk("R3", "mdc", 32'(mdc), 32'(exp_mdc));
            chk(tg, "mdio_oe", 32'(mdio_oe), 32'(exp_drv[1]));
            chk(tg, "mdio_o", 32'(mdio_o), 32'(exp_drv[0]));
            chk("R9", "busy", 32'(busy), 32'(m_busy));
            chk("R9", "done", 32'(done), 32'(m_done));
            chk(m_ta ? "R8" : "R9", "rd_data", 32'(rd_data), 32'(m_rd_out));
            chk(m_ta ? "R8" : "R9", "err", 32'(err), 32'(m_err_out));
        end
        // PHY answers during turnaround check and data slots of a read
        if (m_busy && m_rd && slot >= 47 && slot <= 63 && !(m_ta && slot >= 48)) begin
            phy_en = 1'b1;
            phy_val = (slot == 47) ? m_ta : m_data[63 - slot];
            if (ph_late && (m_n % (2 * H)) >= 2 * H - 2) phy_val = ~phy_val;
        end else begin
            phy_en = 1'b0;
            phy_val = 1'b1;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !finished) begin
            nfail++;
            $display("FAIL R9 watchdog actual=%0d expected=<60000 cycles", cycles);
            summary();
        end
    end

    task automatic txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input bit ta, input logic [15:0] pd,
                       input bit late, input bit intr, input string tag);
        int k;
        ph_ta = ta; ph_data = pd; ph_late = late;
        @(negedge clk);
        rd_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after accept", 32'(busy), 32'd1);
        if (intr) begin
            repeat (60) @(negedge clk);
            rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R2", "busy after stray start", 32'(busy), 32'd1);
        end
        k = 0;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk("R9", "done seen", 32'(done), 32'd1);
        chk(tag, "result data", 32'(rd_data), 32'((rd && !ta) ? pd : 16'h0));
        chk(tag, "result err", 32'(err), 32'(rd && ta));
        @(negedge clk);
        chk("R9", "done dropped", 32'(done), 32'd0);
        chk("R9", "data held", 32'(rd_data), 32'((rd && !ta) ? pd : 16'h0));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "reset busy", 32'(busy), 32'd0);
        chk("R1", "reset mdc", 32'(mdc), 32'd0);
        chk("R1", "reset oe", 32'(mdio_oe), 32'd0);
        chk("R1", "reset done", 32'(done), 32'd0);
        chk("R1", "reset rd_data", 32'(rd_data), 32'd0);
        chk("R1", "reset err", 32'(err), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        txn(1'b0, 5'h11, 5'h0A, 16'hA55A, 1'b0, 16'h0000, 1'b0, 1'b0, "R6");
        txn(1'b1, 5'h1F, 5'h00, 16'h0000, 1'b0, 16'h8001, 1'b0, 1'b0, "R7");
        txn(1'b1, 5'h03, 5'h12, 16'h0000, 1'b1, 16'hBEEF, 1'b0, 1'b0, "R8");
        txn(1'b1, 5'h03, 5'h12, 16'h0000, 1'b0, 16'h3C96, 1'b0, 1'b1, "R2");
        txn(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b0, 16'h5A0F, 1'b1, 1'b0, "R10");
        txn(1'b0, 5'h00, 5'h1F, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b1, "R6");
        chk("R1", "idle oe at end", 32'(mdio_oe), 32'd0);
        summary();
    end

endmodule